// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It cycles without end through three phases: offset cancellation (autozero), signal integration, and reference de-integration (read). In each phase it drives exactly one of three analog switch enables. It also drives a select that picks the reference polarity. Autozero and integrate each run for a fixed number of clocks. The read phase runs until the comparator shows that the integrator has come back to its starting level. The number of clocks spent in read is the conversion result.

When read ends, the result is copied into output latches together with the input sign and an overrange flag. A one-cycle valid strobe goes with each update. The counter is freed at the same moment and the next autozero begins. The comparator arrives asynchronously, so it passes through a two-stage synchronizer before any logic uses it.

Top module: `dsadc_seq`

## Requirements
- R1: The active phase always moves autozero → integrate → read → autozero, and this repeats without end.
- R2: Autozero lasts exactly FIX_CYCLES clocks.
- R3: Integrate lasts exactly FIX_CYCLES clocks.
- R4: In every clock after reset, exactly one of `az_en`, `integ_en` and `read_en` is high.
- R5: In the last integrate cycle the block samples the synchronized comparator (1 = integrator above its autozero level, meaning a positive input). `ref_neg` takes that value, so a positive input selects the negative reference. The value holds unchanged through the whole read phase.
- R6: `cmp_in` goes through two flops, so a change applied before the clock edge that ends read cycle k is seen in read cycle k+2. Read cycles are numbered from 0. Read ends in the first cycle where the synchronized comparator differs from the sampled polarity, and the number of that cycle is the result.
- R7: If no crossing has been seen by read cycle READ_MAX, read is forced to end in that cycle. The result saturates at READ_MAX and `res_ovr` is 1. A crossing seen in cycle READ_MAX itself gives READ_MAX with `res_ovr` = 0.
- R8: `result`, `res_pos` and `res_ovr` change only together with a `res_valid` pulse. The pulse is one cycle wide and falls in the first autozero cycle of the next measurement.
- R9: Asynchronous reset puts the block in the first autozero cycle: `az_en` = 1, every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Raw comparator output, 1 = integrator above autozero level |
| az_en | output | 1 | Autozero switch enable |
| integ_en | output | 1 | Input integration switch enable |
| read_en | output | 1 | Reference de-integration switch enable |
| ref_neg | output | 1 | 1 selects the negative reference during read |
| result | output | CNT_W | Latched read-phase clock count |
| res_pos | output | 1 | Latched input sign, 1 = positive |
| res_ovr | output | 1 | Latched overrange flag |
| res_valid | output | 1 | One-cycle strobe marking a latch update |

## Verification
The bench builds the block with FIX_CYCLES = 8 and READ_MAX = 20. With these values a whole measurement takes a few dozen clocks, so both input signs, crossings in the first cycle the synchronizer allows, and crossings in the middle of read can all be run in one short test. The same sizes make the saturation limit reachable. The bench hits read cycle READ_MAX exactly with a crossing, then one cycle later with none, and then with no crossing at all.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  // Width able to hold the largest count any phase reaches.
  function automatic int unsigned f_cnt_w(input int unsigned fix_c, input int unsigned rd_max);
    int unsigned top;
    top = (fix_c > rd_max) ? fix_c : rd_max;
    return $clog2(top + 1);
  endfunction

  // The integrator is back at its start level once the comparator leaves the sampled sign.
  function automatic logic f_crossed(input logic cmp_now, input logic held_pos);
    return cmp_now != held_pos;
  endfunction

  // The overrange flag is raised only when the limit is hit without a crossing.
  function automatic logic f_overrange(input logic crossed, input logic at_limit);
    return at_limit && !crossed;
  endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int FIX_CYCLES = 1000,
  parameter int READ_MAX   = 2000,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_s,
  output logic             az_en,
  output logic             integ_en,
  output logic             read_en,
  output logic             pos_q,
  output logic             rd_done,
  output logic             rd_ovr,
  output logic [CNT_W-1:0] rd_count
);
  localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIX_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LIMIT = CNT_W'(READ_MAX);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pos_d;
  logic             crossed, at_limit, fix_end;

  assign crossed  = f_crossed(cmp_s, pos_q);
  assign at_limit = (cnt_q == RD_LIMIT);
  assign fix_end  = (cnt_q == FIX_LAST);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    pos_d   = pos_q;
    rd_done = 1'b0;
    rd_ovr  = 1'b0;
    unique case (phase_q)
      PH_AZ: if (fix_end) begin
        phase_d = PH_INT;
        cnt_d   = '0;
      end
      PH_INT: if (fix_end) begin
        phase_d = PH_RD;
        cnt_d   = '0;
        pos_d   = cmp_s;
      end
      PH_RD: if (crossed || at_limit) begin
        phase_d = PH_AZ;
        cnt_d   = '0;
        rd_done = 1'b1;
        rd_ovr  = f_overrange(crossed, at_limit);
      end
      default: begin
        phase_d = PH_AZ;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_AZ;
      cnt_q    <= '0;
      pos_q    <= 1'b0;
      az_en    <= 1'b1;
      integ_en <= 1'b0;
      read_en  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      pos_q    <= pos_d;
      az_en    <= (phase_d == PH_AZ);
      integ_en <= (phase_d == PH_INT);
      read_en  <= (phase_d == PH_RD);
    end
  end

  assign rd_count = cnt_q;

  // R4: one switch enable at a time
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({az_en, integ_en, read_en}));

  // R1: integrate only follows autozero, read only follows integrate, autozero only follows read
  p_order_int_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(integ_en) |-> $past(az_en));
  p_order_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_en) |-> $past(integ_en));
  p_order_az_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(az_en) |-> $past(read_en));

  // R2 / R3: fixed phases leave only from their last count
  p_az_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(az_en) |-> ($past(cnt_q) == FIX_LAST));
  p_int_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_en) |-> ($past(cnt_q) == FIX_LAST));

  // R5: reference polarity held through read
  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && $past(read_en)) |-> $stable(pos_q));

  // R7: read counter never passes the limit
  p_rd_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    read_en |-> (cnt_q <= RD_LIMIT));
endmodule

// File: rtl/dsadc_result_latch.sv
module dsadc_result_latch #(
  parameter int CNT_W    = 11,
  parameter int READ_MAX = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_done,
  input  logic             rd_ovr,
  input  logic             pos,
  input  logic [CNT_W-1:0] rd_count,
  output logic [CNT_W-1:0] result,
  output logic             res_pos,
  output logic             res_ovr,
  output logic             res_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      res_pos   <= 1'b0;
      res_ovr   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= rd_done;
      if (rd_done) begin
        result  <= rd_count;
        res_pos <= pos;
        res_ovr <= rd_ovr;
      end
    end
  end

  // R8: strobe is a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R8: latches move only with a strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(result) && $stable(res_pos) && $stable(res_ovr)));
  // R7: overrange always reports the saturated count
  p_ovr_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovr) |-> (result == CNT_W'(READ_MAX)));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int FIX_CYCLES = 1000,
  parameter int READ_MAX   = 2000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = f_cnt_w(FIX_CYCLES, READ_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  output logic             az_en,
  output logic             integ_en,
  output logic             read_en,
  output logic             ref_neg,
  output logic [CNT_W-1:0] result,
  output logic             res_pos,
  output logic             res_ovr,
  output logic             res_valid
);
  logic             cmp_s;
  logic             pos_q;
  logic             rd_done, rd_ovr;
  logic [CNT_W-1:0] rd_count;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_s)
  );

  dsadc_phase_ctrl #(
    .FIX_CYCLES(FIX_CYCLES), .READ_MAX(READ_MAX), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_s(cmp_s),
    .az_en(az_en), .integ_en(integ_en), .read_en(read_en),
    .pos_q(pos_q), .rd_done(rd_done), .rd_ovr(rd_ovr), .rd_count(rd_count)
  );

  dsadc_result_latch #(.CNT_W(CNT_W), .READ_MAX(READ_MAX)) u_latch (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_ovr(rd_ovr),
    .pos(pos_q), .rd_count(rd_count),
    .result(result), .res_pos(res_pos), .res_ovr(res_ovr), .res_valid(res_valid)
  );

  // Positive input sampled -> negative reference applied
  assign ref_neg = pos_q;

  // R8: strobe lands in the first autozero cycle
  p_valid_az_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (az_en && $past(read_en)));
endmodule

// File: tb/dsadc_seq_tb.sv
module dsadc_seq_tb;
  localparam int FIX  = 8;
  localparam int RMAX = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_in = 1'b0;
  logic az_en, integ_en, read_en, ref_neg, res_pos, res_ovr, res_valid;
  logic [4:0] result;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;

  typedef struct { int cnt; bit pos; bit ovr; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  dsadc_seq #(.FIX_CYCLES(FIX), .READ_MAX(RMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
    .az_en(az_en), .integ_en(integ_en), .read_en(read_en), .ref_neg(ref_neg),
    .result(result), .res_pos(res_pos), .res_ovr(res_ovr), .res_valid(res_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // Driver: one measurement with the given sign; the flip of cmp_in is applied n cycles into read.
  task automatic convert(input bit sign, input int n);
    exp_t e;
    int c;
    cmp_in = sign;
    do @(negedge clk); while (!read_en);
    chk(ref_neg == sign, "R5 ref_neg at read start", int'(ref_neg), int'(sign));
    c = n + 2;
    e.pos = sign;
    e.ovr = (c > RMAX);
    e.cnt = e.ovr ? RMAX : c;
    sb.push_back(e);
    if (c <= RMAX) begin
      repeat (n) @(negedge clk);
      cmp_in = ~sign;
    end
    do @(negedge clk); while (!az_en);
  endtask

  // Monitor: phase sequence, lengths, one-hot, polarity hold and scoreboard
  logic [2:0] prev_ph = 3'b100;
  int run_len = 0;
  int last_res = 0;
  bit last_pos = 1'b0, last_ovr = 1'b0;
  bit prev_valid = 1'b0;
  bit prev_ref = 1'b0;
  always @(negedge clk) if (mon_on) begin
    logic [2:0] ph;
    exp_t e;
    ph = {az_en, integ_en, read_en};
    chk($countones(ph) == 1, "R4 onehot enables", int'(ph), 1);
    if (ph != prev_ph) begin
      if (prev_ph == 3'b100) begin
        chk(ph == 3'b010, "R1 after autozero", int'(ph), 2);
        chk(run_len == FIX, "R2 autozero length", run_len, FIX);
      end else if (prev_ph == 3'b010) begin
        chk(ph == 3'b001, "R1 after integrate", int'(ph), 1);
        chk(run_len == FIX, "R3 integrate length", run_len, FIX);
      end else begin
        chk(ph == 3'b100, "R1 after read", int'(ph), 4);
      end
      run_len = 1;
    end else begin
      run_len++;
      if (read_en)
        chk(ref_neg == prev_ref, "R5 ref_neg held in read", int'(ref_neg), int'(prev_ref));
    end
    if (res_valid) begin
      chk(!prev_valid, "R8 valid width", 1, 0);
      chk(az_en && prev_ph == 3'b001, "R8 valid in first autozero", int'(ph), 4);
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected valid", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(int'(result) == e.cnt, "R6/R7 result", int'(result), e.cnt);
        chk(res_pos == e.pos, "R5 latched sign", int'(res_pos), int'(e.pos));
        chk(res_ovr == e.ovr, "R7 overrange flag", int'(res_ovr), int'(e.ovr));
      end
      last_res = int'(result); last_pos = res_pos; last_ovr = res_ovr;
    end else begin
      chk(int'(result) == last_res && res_pos == last_pos && res_ovr == last_ovr,
          "R8 latch hold", int'(result), last_res);
    end
    prev_valid = res_valid;
    prev_ph = ph;
    prev_ref = ref_neg;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(az_en && !integ_en && !read_en, "R9 reset enables", int'({az_en, integ_en, read_en}), 4);
    chk(!ref_neg && !res_valid && !res_ovr && !res_pos, "R9 reset flags", 1, 0);
    chk(result == 0, "R9 reset result", int'(result), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    convert(1'b1, 0);    // R6: earliest crossing, positive
    convert(1'b0, 0);    // R6: earliest crossing, negative
    convert(1'b1, 5);
    convert(1'b0, 9);
    convert(1'b1, RMAX - 2);  // R7: crossing exactly at the limit
    convert(1'b0, RMAX - 1);  // R7: one cycle late -> overrange
    convert(1'b1, 40);        // R7: never crosses
    convert(1'b0, 1);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R8 all results delivered", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule